// File: doc/BRIEF.md
# Descriptor-Fetching Memory Copy Channel

This block is one memory-to-memory copy channel. Software does not load the transfer parameters into registers. It writes them as a four-word descriptor in memory, loads the descriptor's address into a pointer register, and sets a run bit. The channel then reads the descriptor through its own memory master port and copies the requested number of 32-bit words from a source address to a destination address. The descriptor selects whether the source and destination addresses advance. When the copy ends, the run bit clears by itself. If the descriptor asked for it, the channel raises an interrupt that stays asserted until software writes 1 to the flag bit.

The memory master port carries one word per access, using a request/grant handshake. The controller is built around five named states:
- `ST_IDLE`: waits for a start.
- `ST_FETCH`: reads descriptor words 0 to 3.
- `ST_READ`: reads one source word.
- `ST_WRITE`: writes that word to the destination.
- `ST_FINISH`: a single cycle that ends the transfer.

The transitions are:
- `ST_IDLE` goes to `ST_FETCH` on start.
- `ST_FETCH` stays in `ST_FETCH` until the fourth word is granted. It then goes to `ST_FINISH` when the fetched length is zero, and to `ST_READ` otherwise.
- `ST_READ` goes to `ST_WRITE` on grant.
- `ST_WRITE` goes to `ST_READ` on grant while more than one word remains, and to `ST_FINISH` on grant of the last word.
- `ST_FINISH` goes to `ST_IDLE` unconditionally.

Top module: `dma_cb_channel`

## Requirements
- R1: After reset the control/status register reads 0, the pointer register reads 0, `irq` is low and `mem_req` is low.
- R2: The control/status register is at register offset 0x0, with the run bit at bit 0 and the interrupt flag at bit 2. The descriptor pointer is at offset 0x4 and reads back what was written.
- R3: Writing 1 to bit 0 of the control/status register while idle starts four descriptor reads, at pointer+0, +4, +8 and +12, in that order. These words are transfer-info, source address, destination address and length in bytes.
- R4: Bit 0 of transfer-info enables the completion interrupt, bit 4 makes the destination advance by 4 per word, and bit 8 makes the source advance by 4 per word. A clear increment bit keeps that address fixed.
- R5: Each word moves as one read of the source followed by one write of the same data to the destination.
- R6: Every access holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until `mem_gnt` is seen, and the channel proceeds only after the grant.
- R7: The length counts down by 4 per word moved, so a length of 4·N bytes gives exactly N reads and N writes of data.
- R8: A length of 0 ends the transfer right after the descriptor fetch, with no data access.
- R9: Bit 0 of the control/status register reads 1 from the start until the transfer completes, then returns to 0 by itself.
- R10: Writing 1 to the run bit while a transfer is in progress has no effect: no second descriptor fetch and no extra data access.
- R11: At completion with the interrupt-enable bit set, the flag and `irq` become 1 in the same cycle the run bit clears. With the interrupt-enable bit clear, they stay 0.
- R12: Writing 1 to bit 2 of the control/status register clears the flag and `irq`. Writing 0 to bit 2 leaves them set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_gnt | input | 1 | Access accepted this cycle; read data valid |
| mem_rdata | input | DATA_W | Read data, valid with `mem_gnt` |
| irq | output | 1 | Completion interrupt (level) |

## Verification
The hardest state to reach from the ports is the channel halfway through a descriptor fetch or a copy while the register port writes the run bit again. An unintended restart would leave no trace in the final register values. The bench therefore sets a grant delay of zero to two cycles for each run, so the transfers are stretched, and writes the run bit again mid-transfer. It then counts every descriptor, read and write access that the memory model grants. The sweep covers lengths of 0 to 5 words, all four increment combinations and both interrupt-enable settings. The expected destination contents come from arithmetic on the source pattern: with a fixed destination, only the last word read must survive.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } dma_state_e;

    // register offsets and control/status bits
    localparam int CSR_OFS       = 0;
    localparam int PTR_OFS       = 4;
    localparam int CSR_RUN_BIT   = 0;
    localparam int CSR_FLAG_BIT  = 2;

    // transfer-info bits
    localparam int INFO_IRQEN_BIT = 0;
    localparam int INFO_DINC_BIT  = 4;
    localparam int INFO_SINC_BIT  = 8;

    localparam int DESC_WORDS = 4;

endpackage

// File: rtl/dma_cb_regs.sv
module dma_cb_regs
    import dma_cb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              set_flag,
    output logic [ADDR_W-1:0] desc_ptr,
    output logic              start,
    output logic              flag
);

    logic csr_sel;
    logic ptr_sel;

    assign csr_sel = (reg_addr == REG_AW'(CSR_OFS));
    assign ptr_sel = (reg_addr == REG_AW'(PTR_OFS));

    // the run bit only starts an idle channel
    assign start = reg_wr && csr_sel && reg_wdata[CSR_RUN_BIT] && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc_ptr <= '0;
            flag     <= 1'b0;
        end else begin
            if (reg_wr && ptr_sel) begin
                desc_ptr <= reg_wdata[ADDR_W-1:0];
            end
            // completion wins over a simultaneous clear
            if (set_flag) begin
                flag <= 1'b1;
            end else if (reg_wr && csr_sel && reg_wdata[CSR_FLAG_BIT]) begin
                flag <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (csr_sel) begin
            reg_rdata[CSR_RUN_BIT]  = busy;
            reg_rdata[CSR_FLAG_BIT] = flag;
        end else if (ptr_sel) begin
            reg_rdata[ADDR_W-1:0] = desc_ptr;
        end
    end

endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
    import dma_cb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] desc_ptr,
    output logic              busy,
    output logic              finish,
    output logic              set_flag,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int                BYTES = DATA_W / 8;
    localparam int                IDX_W = $clog2(DESC_WORDS);
    localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(BYTES);
    localparam logic [DATA_W-1:0] LSTEP = DATA_W'(BYTES);

    dma_state_e        state, nxt;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] ptr_q, src_q, dst_q;
    logic [DATA_W-1:0] info_q, len_q, data_q;
    logic              last_fetch, last_word;

    assign last_fetch = (idx == IDX_W'(DESC_WORDS - 1));
    assign last_word  = (len_q <= LSTEP);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  if (mem_gnt && last_fetch)
                           nxt = (mem_rdata == '0) ? ST_FINISH : ST_READ;
            ST_READ:   if (mem_gnt) nxt = ST_WRITE;
            ST_WRITE:  if (mem_gnt) nxt = last_word ? ST_FINISH : ST_READ;
            ST_FINISH: nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // descriptor, address and length datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx    <= '0;
            ptr_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            info_q <= '0;
            len_q  <= '0;
            data_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    ptr_q <= desc_ptr;
                    idx   <= '0;
                end
                ST_FETCH: if (mem_gnt) begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_W'(0))      info_q <= mem_rdata;
                    else if (idx == IDX_W'(1)) src_q  <= mem_rdata[ADDR_W-1:0];
                    else if (idx == IDX_W'(2)) dst_q  <= mem_rdata[ADDR_W-1:0];
                    else                       len_q  <= mem_rdata;
                end
                ST_READ: if (mem_gnt) data_q <= mem_rdata;
                ST_WRITE: if (mem_gnt) begin
                    if (info_q[INFO_SINC_BIT]) src_q <= src_q + ASTEP;
                    if (info_q[INFO_DINC_BIT]) dst_q <= dst_q + ASTEP;
                    len_q <= len_q - LSTEP;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = ptr_q + (ADDR_W'(idx) * ASTEP);
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_q;
                mem_wdata = data_q;
            end
            default: ;
        endcase
    end

    assign busy     = (state != ST_IDLE);
    assign finish   = (state == ST_FINISH);
    assign set_flag = finish && info_q[INFO_IRQEN_BIT];

endmodule

// File: rtl/dma_cb_channel.sv
module dma_cb_channel
    import dma_cb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);

    logic              busy;
    logic              finish;
    logic              set_flag;
    logic              start;
    logic              flag;
    logic [ADDR_W-1:0] desc_ptr;

    dma_cb_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .REG_AW (REG_AW)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .set_flag  (set_flag),
        .desc_ptr  (desc_ptr),
        .start     (start),
        .flag      (flag)
    );

    dma_cb_engine #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .desc_ptr  (desc_ptr),
        .busy      (busy),
        .finish    (finish),
        .set_flag  (set_flag),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_gnt   (mem_gnt),
        .mem_rdata (mem_rdata)
    );

    assign irq = flag;

endmodule

// File: rtl/dma_cb_checks.sv
module dma_cb_checks #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int REG_AW = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [REG_AW-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_gnt,
    input logic              irq,
    input logic              busy,
    input logic              finish
);

    // R6: an ungranted request keeps its contents
    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

    // R1: no memory traffic while idle
    p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: interrupt rises only as the channel goes idle
    p_irq_at_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $fell(busy));

    // R12: a write of 1 to the flag bit clears it unless completion coincides
    p_flag_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == REG_AW'(0) && reg_wdata[2] && !finish |=> !irq);

    // R9: starting an idle channel makes it busy
    p_run_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && reg_wr && reg_addr == REG_AW'(0) && reg_wdata[0] |=> busy);

endmodule

bind dma_cb_channel dma_cb_checks #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .REG_AW (REG_AW)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_gnt   (mem_gnt),
    .irq       (irq),
    .busy      (busy),
    .finish    (finish)
);

// File: tb/tb_dma_cb_channel.sv
`timescale 1ns/1ps
module tb_dma_cb_channel;

    localparam int DW = 32;
    localparam int AW = 32;
    localparam int RW = 4;
    localparam logic [31:0] SRC_BASE  = 32'h40;
    localparam logic [31:0] DST_BASE  = 32'h80;
    localparam logic [31:0] DESC_BASE = 32'h100;
    localparam logic [31:0] FILL      = 32'hDEAD_0000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [RW-1:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          mem_req, mem_we, mem_gnt, irq;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;

    always #10 clk = ~clk;

    dma_cb_channel #(.DATA_W(DW), .ADDR_W(AW), .REG_AW(RW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .irq(irq)
    );

    // memory model with grant delay and access monitor
    logic [31:0] mem [0:127];
    logic [2:0]  gdly = '0;
    logic [2:0]  wait_cnt;
    logic        bk_we = 1'b0;
    logic [6:0]  bk_idx = '0;
    logic [31:0] bk_data = '0;
    logic        cnt_clr = 1'b0;
    int          fetch_cnt, fetch_err, rd_cnt, wr_cnt, order_err;
    logic        last_rd;

    assign mem_gnt   = mem_req && (wait_cnt >= gdly);
    assign mem_rdata = mem[mem_addr[8:2]];

    always @(posedge clk) begin
        if (!rst_n || !mem_req || mem_gnt) wait_cnt <= '0;
        else                               wait_cnt <= wait_cnt + 1'b1;
        if (bk_we) mem[bk_idx] <= bk_data;
        if (cnt_clr) begin
            fetch_cnt <= 0; fetch_err <= 0; rd_cnt <= 0; wr_cnt <= 0;
            order_err <= 0; last_rd <= 1'b0;
        end else if (mem_req && mem_gnt) begin
            if (mem_addr >= DESC_BASE && mem_addr < DESC_BASE + 16) begin
                if (mem_addr != DESC_BASE + 32'(fetch_cnt * 4)) fetch_err <= fetch_err + 1;
                fetch_cnt <= fetch_cnt + 1;
            end else if (mem_we) begin
                mem[mem_addr[8:2]] <= mem_wdata;
                wr_cnt <= wr_cnt + 1;
                if (!last_rd) order_err <= order_err + 1;
                last_rd <= 1'b0;
            end else begin
                rd_cnt <= rd_cnt + 1;
                if (last_rd) order_err <= order_err + 1;
                last_rd <= 1'b1;
            end
        end
    end

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bk_we = 1'b1; bk_idx = addr[8:2]; bk_data = data;
        @(negedge clk);
        bk_we = 1'b0;
    endtask

    task automatic reg_write(input logic [RW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [RW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] src_val(input int run, input int i);
        return 32'hC0DE_0000 ^ (32'(run) << 8) ^ 32'(i);
    endfunction

    task automatic run_case(input int run, input int nw, input bit si, input bit di,
                            input bit ie, input int gd, input bit again);
        logic [31:0] rd;
        logic [31:0] exp;
        int          bad;
        int          polls;
        gdly = 3'(gd);
        for (int i = 0; i < 6; i++) poke(SRC_BASE + 32'(4 * i), src_val(run, i));
        for (int i = 0; i < 6; i++) poke(DST_BASE + 32'(4 * i), FILL + 32'(i));
        poke(DESC_BASE,      {23'd0, si, 3'd0, di, 3'd0, ie});
        poke(DESC_BASE + 4,  SRC_BASE);
        poke(DESC_BASE + 8,  DST_BASE);
        poke(DESC_BASE + 12, 32'(4 * nw));
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        reg_write(4'h4, DESC_BASE);
        reg_write(4'h0, 32'h1);
        reg_read(4'h0, rd);
        check(rd[0] == 1'b1, "R9 run bit set while busy", rd, 32'h1);
        if (again) reg_write(4'h0, 32'h1);   // R10: ignored restart
        polls = 0;
        do begin
            reg_read(4'h0, rd);
            polls++;
        end while (rd[0] && polls < 400);
        check(rd[0] == 1'b0, "R9 run bit self-clears", rd, 32'h0);
        check(fetch_cnt == 4 && fetch_err == 0, "R3 descriptor fetch order", 32'(fetch_cnt), 32'd4);
        check(rd_cnt == nw, again ? "R10 reads after ignored restart" : "R7 R8 data read count",
              32'(rd_cnt), 32'(nw));
        check(wr_cnt == nw, again ? "R10 writes after ignored restart" : "R7 R8 data write count",
              32'(wr_cnt), 32'(nw));
        check(order_err == 0, "R5 read-then-write pairing", 32'(order_err), 32'd0);
        bad = 0;
        for (int j = 0; j < 6; j++) begin
            exp = FILL + 32'(j);
            if (nw > 0) begin
                if (di && j < nw)      exp = src_val(run, si ? j : 0);
                else if (!di && j == 0) exp = src_val(run, si ? nw - 1 : 0);
            end
            if (mem[(DST_BASE[8:2]) + 7'(j)] !== exp) bad++;
        end
        check(bad == 0, "R4 destination contents", 32'(bad), 32'd0);
        check(irq == ie && rd[2] == ie, "R11 completion flag and irq", {rd[31:1], irq}, {29'd0, ie, 1'b0, ie});
        if (ie) begin
            reg_write(4'h0, 32'h0);
            check(irq == 1'b1, "R12 write of 0 keeps flag", {31'd0, irq}, 32'h1);
            reg_write(4'h0, 32'h4);
            reg_read(4'h0, rd);
            check(irq == 1'b0 && rd[2] == 1'b0, "R12 write of 1 clears flag", rd, 32'h0);
        end
    endtask

    initial begin
        logic [31:0] rd;
        int run;
        for (int i = 0; i < 128; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reg_read(4'h0, rd);
        check(rd == 32'h0, "R1 control/status after reset", rd, 32'h0);
        reg_read(4'h4, rd);
        check(rd == 32'h0, "R1 pointer after reset", rd, 32'h0);
        check(irq == 1'b0 && mem_req == 1'b0, "R1 irq and request low", {30'd0, irq, mem_req}, 32'h0);
        reg_write(4'h4, 32'h0000_0ABC);
        reg_read(4'h4, rd);
        check(rd == 32'h0000_0ABC, "R2 pointer readback", rd, 32'h0000_0ABC);
        run = 0;
        for (int nw = 0; nw <= 5; nw++)
            for (int m = 0; m < 4; m++)
                for (int ie = 0; ie < 2; ie++)
                    for (int gd = 0; gd < 3; gd++) begin
                        run_case(run, nw, m[1], m[0], ie[0], gd, (run % 3) == 1);
                        run++;
                    end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule